// File: doc/BRIEF.md
# Periodic Interval Tick Timer

This block is a programmable periodic timer for a system-control area. It counts down on a slow time-base strobe, nominally 100 kHz, which arrives as a one-cycle enable on the fast system clock. Software writes a period value, and the counter loads it and counts toward zero, one step per strobe. When the count reaches zero, the block sets a sticky timeout flag and raises a high-priority interrupt request. That request is the top level in the system's interrupt scheme. On the next strobe after zero, the counter loads the stored period again, so timeouts repeat at a fixed rate. A hold input freezes the count without losing it.

A small state machine controls the counter. Its three states are `ST_IDLE`, `ST_RUN` and `ST_HOLD`:

- `ST_IDLE`: the timer has no period, or its period is zero.
- `ST_RUN`: the counter advances on each strobe.
- `ST_HOLD`: the hold input is asserted and the count is frozen.

Its transitions are:

- **arm**: from `ST_IDLE`, a nonzero period write moves to `ST_RUN`, or to `ST_HOLD` if the hold input is high.
- **pause**: from `ST_RUN` to `ST_HOLD` when the hold input rises.
- **resume**: from `ST_HOLD` to `ST_RUN` when the hold input falls.
- **disarm**: from `ST_RUN` or `ST_HOLD` to `ST_IDLE` on a zero period write.

The expiry event and the reload are outputs decoded while the machine is in `ST_RUN`.

Top module: `ivt_timer`

## Requirements
- R1: After reset the timeout flag and interrupt output are 0, and no timeout occurs until a nonzero period has been written.
- R2: The count changes only in a cycle where `tick_en` is 1, apart from a period write.
- R3: After a write of nonzero period P, the timeout flag becomes 1 on the P-th counted tick, and not before.
- R4: On the tick after the count reaches zero, the stored period is reloaded, so later timeouts come every P+1 ticks.
- R5: The timeout flag stays 1 until a `clr_stb` pulse. If a timeout and `clr_stb` fall in the same cycle, the flag ends up 1.
- R6: `irq_out` equals the timeout flag in every cycle.
- R7: While `inhibit` is 1, ticks are ignored and the count is frozen. After `inhibit` returns to 0, counting resumes from the frozen value.
- R8: A period write while the timer is counting restarts the count from the new value.
- R9: A write of period 0 stops the timer, and no timeout occurs afterwards.
- R10: When a period write and a tick fall in the same cycle, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle time-base strobe (nominally 100 kHz) |
| period_wr | input | 1 | Period load strobe |
| period_val | input | CNT_W | Period value loaded on `period_wr` |
| inhibit | input | 1 | Count hold; 1 freezes the count |
| clr_stb | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Sticky timeout status |
| irq_out | output | 1 | High-priority interrupt request |

## Verification
The bench builds the block with `CNT_W = 8`. This brings the largest period, 255, within a few hundred strobes, so the table can exercise the all-ones period boundary next to periods of 1, 3 and 5. The bench drives the strobe by hand on chosen cycles. Long gaps without strobes, and strobes that coincide with writes, clears or the hold input, can therefore be placed exactly.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ivt_state_e;
endpackage

// File: rtl/ivt_ctrl_fsm.sv
module ivt_ctrl_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic inhibit,
    input  logic period_wr,
    input  logic period_nz,
    input  logic cnt_zero,
    output logic dec_en,
    output logic reload_en,
    output ivt_state_e state_o
);
    ivt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode: arm, pause, resume, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (period_wr && period_nz)
                    state_d = inhibit ? ST_HOLD : ST_RUN;   // arm
            end
            ST_RUN: begin
                if (period_wr && !period_nz) state_d = ST_IDLE;  // disarm
                else if (inhibit)            state_d = ST_HOLD;  // pause
            end
            ST_HOLD: begin
                if (period_wr && !period_nz) state_d = ST_IDLE;  // disarm
                else if (!inhibit)           state_d = ST_RUN;   // resume
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode: a tick counts only when running, not held, not overridden by a write
    always_comb begin
        logic active;
        active    = (state_q == ST_RUN) && !inhibit && tick_en && !period_wr;
        dec_en    = active && !cnt_zero;
        reload_en = active && cnt_zero;
    end

    assign state_o = state_q;
endmodule

// File: rtl/ivt_downcount.sv
module ivt_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_val,
    input  logic             dec_en,
    input  logic             reload_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_zero,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
        end else if (period_wr) begin
            period_q <= period_val;
            cnt_q    <= period_val;
        end else if (reload_en) begin
            cnt_q    <= period_q;
        end else if (dec_en) begin
            cnt_q    <= cnt_q - ONE;
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign expire   = dec_en && (cnt_q == ONE);
    assign cnt_o    = cnt_q;
endmodule

// File: rtl/ivt_flag.sv
module ivt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;   // a new timeout beats a clear
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_val,
    input  logic             inhibit,
    input  logic             clr_stb,
    output logic             timeout_flag,
    output logic             irq_out
);
    logic             dec_en, reload_en, cnt_zero, expire;
    logic [CNT_W-1:0] cnt_q;
    ivt_state_e       state_q;

    ivt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .inhibit   (inhibit),
        .period_wr (period_wr),
        .period_nz (period_val != '0),
        .cnt_zero  (cnt_zero),
        .dec_en    (dec_en),
        .reload_en (reload_en),
        .state_o   (state_q)
    );

    ivt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_wr  (period_wr),
        .period_val (period_val),
        .dec_en     (dec_en),
        .reload_en  (reload_en),
        .cnt_o      (cnt_q),
        .cnt_zero   (cnt_zero),
        .expire     (expire)
    );

    ivt_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .clr_i  (clr_stb),
        .flag_o (timeout_flag)
    );

    assign irq_out = timeout_flag;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             period_wr,
    input logic [CNT_W-1:0] period_val,
    input logic             inhibit,
    input logic             clr_stb,
    input logic             timeout_flag,
    input logic [CNT_W-1:0] cnt_q
);
    assert_count_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !period_wr) |=> $stable(cnt_q));

    assert_flag_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(tick_en));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clr_stb) |=> timeout_flag);

    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !period_wr) |=> $stable(cnt_q));

    assert_write_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (cnt_q == $past(period_val)));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .period_wr    (period_wr),
    .period_val   (period_val),
    .inhibit      (inhibit),
    .clr_stb      (clr_stb),
    .timeout_flag (timeout_flag),
    .cnt_q        (cnt_q)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    localparam int CNT_W = 8;
    localparam int NVEC  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             period_wr = 1'b0;
    logic [CNT_W-1:0] period_val = '0;
    logic             inhibit = 1'b0;
    logic             clr_stb = 1'b0;
    logic             timeout_flag, irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ivt_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_wr(period_wr),
        .period_val(period_val), .inhibit(inhibit), .clr_stb(clr_stb),
        .timeout_flag(timeout_flag), .irq_out(irq_out)
    );

    // {period, ticks applied, expected flag}
    typedef struct packed {
        logic [7:0]  per;
        logic [15:0] nt;
        logic        exp;
    } vec_t;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1,   16'd0,   1'b0}, '{8'd1,   16'd1,   1'b1},
        '{8'd3,   16'd2,   1'b0}, '{8'd3,   16'd3,   1'b1},
        '{8'd5,   16'd4,   1'b0}, '{8'd5,   16'd5,   1'b1},
        '{8'd255, 16'd254, 1'b0}, '{8'd255, 16'd255, 1'b1}
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic load(input int p);
        @(negedge clk) begin period_wr = 1'b1; period_val = CNT_W'(p); end
        @(negedge clk) period_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) clr_stb = 1'b1;
        @(negedge clk) clr_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(timeout_flag, 1'b0, "R1 flag after reset");
        check(irq_out, 1'b0, "R1 irq after reset");
        ticks(10);
        check(timeout_flag, 1'b0, "R1 no timeout without period");

        // Table walk: R3 expiry on P-th tick, R6 irq tracks flag
        for (int v = 0; v < NVEC; v++) begin
            load(int'(VECS[v].per));
            ticks(int'(VECS[v].nt));
            check(timeout_flag, VECS[v].exp, "R3 table expiry");
            check(irq_out, VECS[v].exp, "R6 irq follows flag");
            clear_flag();
        end

        // R4 periodic reload: P=2 gives timeouts every 3 ticks
        load(2); ticks(2);
        check(timeout_flag, 1'b1, "R4 first timeout");
        clear_flag();
        ticks(2);
        check(timeout_flag, 1'b0, "R4 no early repeat");
        ticks(1);
        check(timeout_flag, 1'b1, "R4 repeat after P+1 ticks");
        clear_flag();

        // R2 no strobes: count holds
        load(2);
        repeat (20) @(negedge clk);
        check(timeout_flag, 1'b0, "R2 idle cycles ignored");
        ticks(2);
        check(timeout_flag, 1'b1, "R2 ticks counted");

        // R5 sticky and clear priority
        ticks(3);
        check(timeout_flag, 1'b1, "R5 flag sticky");
        clear_flag();
        check(timeout_flag, 1'b0, "R5 flag cleared");
        load(1);
        @(negedge clk) begin tick_en = 1'b1; clr_stb = 1'b1; end
        @(negedge clk) begin tick_en = 1'b0; clr_stb = 1'b0; end
        check(timeout_flag, 1'b1, "R5 set beats clear");
        check(irq_out, 1'b1, "R6 irq high with flag");
        clear_flag();
        check(irq_out, 1'b0, "R6 irq low with flag");

        // R7 hold freezes, resume from frozen value
        load(4); ticks(2);
        @(negedge clk) inhibit = 1'b1;
        ticks(10);
        check(timeout_flag, 1'b0, "R7 frozen while held");
        @(negedge clk) inhibit = 1'b0;
        ticks(1);
        check(timeout_flag, 1'b0, "R7 resumed one tick");
        ticks(1);
        check(timeout_flag, 1'b1, "R7 resumed from frozen value");
        clear_flag();

        // R8 restart on rewrite
        load(3); ticks(2);
        load(3); ticks(2);
        check(timeout_flag, 1'b0, "R8 restart no early timeout");
        ticks(1);
        check(timeout_flag, 1'b1, "R8 restart timeout");
        clear_flag();

        // R9 zero period stops
        load(3); ticks(1);
        load(0); ticks(10);
        check(timeout_flag, 1'b0, "R9 stopped");

        // R10 write beats coincident tick
        @(negedge clk) begin period_wr = 1'b1; period_val = 8'd2; tick_en = 1'b1; end
        @(negedge clk) begin period_wr = 1'b0; tick_en = 1'b0; end
        ticks(1);
        check(timeout_flag, 1'b0, "R10 coincident tick dropped");
        ticks(1);
        check(timeout_flag, 1'b1, "R10 timeout after two ticks");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule